// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead Time

This block sits between a modulator and the two gate drivers of one half-bridge leg. It takes a command for the upper switch and a command for the lower switch, and it produces two gate-enable outputs. Each output has the same polarity as its command. The block guarantees that the two switches never conduct together.

If the modulator asks for both switches at once, the block turns both off. After any gate turns off, neither gate may turn on again until a programmable dead interval has passed with both gates low. This holds for a switch-over between sides and for a re-turn-on of the same side. An active-low shutdown input from the protection logic forces both gates off whatever the commands are.

All three inputs pass through the same synchronizer depth. The upper and lower paths are built from identical logic, so they have equal latency.

Top module: `hb_interlock`

## Requirements
- R1: Each gate output is non-inverting with respect to its own command. A gate is high only if its command was high when sampled three clock edges earlier. A command that falls just after a clock edge turns its gate off at the third edge after that one.
- R2: `hi_gate_o` and `lo_gate_o` are never high in the same cycle.
- R3: While both commands are high, both gates go low within three edges and stay low.
- R4: A command that rises just after edge 0 turns its gate on at edge `DEAD_CYCLES+2`, provided the opposite gate is low and the opposite command is low. The gate is still low at edge `DEAD_CYCLES+1`.
- R5: When one gate turns off and the other side is commanded, the other gate turns on only after exactly `DEAD_CYCLES` full cycles with both gates low. This applies in both directions.
- R6: A gate that turns off because its command dropped briefly waits a full dead interval before it turns on again.
- R7: If a command is removed before its gate has turned on, the countdown is abandoned and the gate stays low. A later command waits the full `DEAD_CYCLES+2` edges again.
- R8: A low level on `shdn_ni` turns both gates off at the third edge. While `shdn_ni` is low, the gates stay off. After `shdn_ni` is released, a held command turns its gate on at edge `DEAD_CYCLES+2`.
- R9: During reset both gates are low. The first turn-on after reset waits the full dead interval.
- R10: The upper and lower paths have identical turn-on and turn-off latencies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hi_cmd_i | input | 1 | Upper switch command, active high |
| lo_cmd_i | input | 1 | Lower switch command, active high |
| shdn_ni | input | 1 | Protection shutdown, active low |
| hi_gate_o | output | 1 | Upper gate enable |
| lo_gate_o | output | 1 | Lower gate enable |

## Verification
Inputs change just after an edge, which the bench calls edge 0. From there, a turn-off is due at edge 3: two synchronizer flops and then the gate flop. A turn-on from idle is due at edge `DEAD_CYCLES+2`. A switch-over is due at edge `DEAD_CYCLES+3`, because the counter starts only once the opposite gate has fallen at edge 3. Each scenario task samples one time unit after the edge before the due edge and again after the due edge, so every check confirms both the old value and the new value at the exact cycle. A running monitor flags any cycle in which both gates are high.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int unsigned SIDE_HI   = 0;
  localparam int unsigned SIDE_LO   = 1;
  localparam int unsigned NUM_SIDES = 2;

  typedef logic [NUM_SIDES-1:0] side_vec_t;

  function automatic int unsigned opposite(input int unsigned side);
    return (side == SIDE_HI) ? SIDE_LO : SIDE_HI;
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= '0;
      else         stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hb_request.sv
// Overlapping commands or an active shutdown cancel both requests.
module hb_request
  import hb_pkg::*;
(
  input  side_vec_t cmd_i,
  input  logic      run_i,
  output side_vec_t req_o
);
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    assign req_o[s] = cmd_i[s] & ~cmd_i[opposite(s)] & run_i;
  end
endmodule

// File: rtl/hb_dead_timer.sv
// Gate rises only after req held for DEAD_CYCLES while the opposite gate is low.
module hb_dead_timer #(
  parameter int unsigned DEAD_CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic other_on_i,
  output logic gate_o
);
  localparam int unsigned CW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEAD_CYCLES - 1);

  logic          qual;
  logic [CW-1:0] cnt_q;
  logic          gate_q;

  assign qual = req_i & ~other_on_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!qual || gate_q) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= qual & (gate_q | (cnt_q == LAST));
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
  import hb_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_cmd_i,
  input  logic lo_cmd_i,
  input  logic shdn_ni,
  output logic hi_gate_o,
  output logic lo_gate_o
);
  localparam int unsigned SYNC_W = NUM_SIDES + 1;

  logic [SYNC_W-1:0] raw;
  logic [SYNC_W-1:0] synced;
  side_vec_t         cmd_s;
  side_vec_t         req;
  side_vec_t         gate;

  assign raw[SIDE_HI] = hi_cmd_i;
  assign raw[SIDE_LO] = lo_cmd_i;
  assign raw[NUM_SIDES] = shdn_ni;

  hb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign cmd_s = synced[NUM_SIDES-1:0];

  hb_request u_req (
    .cmd_i(cmd_s),
    .run_i(synced[NUM_SIDES]),
    .req_o(req)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    hb_dead_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_dt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req[s]),
      .other_on_i(gate[opposite(s)]),
      .gate_o    (gate[s])
    );
  end

  assign hi_gate_o = gate[SIDE_HI];
  assign lo_gate_o = gate[SIDE_LO];
endmodule

// File: rtl/hb_interlock_chk.sv
module hb_interlock_chk #(
  parameter int unsigned DEAD_CYCLES = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hi_cmd_i,
  input logic lo_cmd_i,
  input logic shdn_ni,
  input logic hi_gate_o,
  input logic lo_gate_o
);
  localparam int unsigned LW = $clog2(DEAD_CYCLES + 1);
  localparam int unsigned LAT = SYNC_STAGES + 1;

  logic [LW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt_q <= '0;
    else if (hi_gate_o || lo_gate_o) low_cnt_q <= '0;
    else if (low_cnt_q != LW'(DEAD_CYCLES)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_gate_o && lo_gate_o)); // R2

  AST_HI_FOLLOWS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_gate_o |-> $past(hi_cmd_i, LAT)); // R1

  AST_LO_FOLLOWS_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_gate_o |-> $past(lo_cmd_i, LAT)); // R10

  AST_BOTH_CMD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hi_cmd_i, LAT) && $past(lo_cmd_i, LAT)) |-> !(hi_gate_o || lo_gate_o)); // R3

  AST_SHUTDOWN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(shdn_ni, LAT) |-> !(hi_gate_o || lo_gate_o)); // R8

  AST_DEAD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hi_gate_o) || $rose(lo_gate_o)) |-> (low_cnt_q >= LW'(DEAD_CYCLES))); // R5
endmodule

bind hb_interlock hb_interlock_chk #(
  .DEAD_CYCLES(DEAD_CYCLES),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hi_cmd_i (hi_cmd_i),
  .lo_cmd_i (lo_cmd_i),
  .shdn_ni  (shdn_ni),
  .hi_gate_o(hi_gate_o),
  .lo_gate_o(lo_gate_o)
);

// File: tb/tb_hb_interlock.sv
`timescale 1ns/1ps
module tb_hb_interlock;
  localparam int CLK_PERIOD = 10;
  localparam int DT = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hi_cmd = 1'b0;
  logic lo_cmd = 1'b0;
  logic shdn_n = 1'b1;
  logic hi_gate, lo_gate;

  int checks = 0;
  int failures = 0;
  int overlap_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_interlock #(.DEAD_CYCLES(DT)) dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .hi_cmd_i (hi_cmd),
    .lo_cmd_i (lo_cmd),
    .shdn_ni  (shdn_n),
    .hi_gate_o(hi_gate),
    .lo_gate_o(lo_gate)
  );

  always @(negedge clk) if (rst_ni && hi_gate && lo_gate) overlap_cnt++;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // Advance n edges; sample/drive 1 unit after the last edge.
  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic idle();
    hi_cmd = 1'b0; lo_cmd = 1'b0; shdn_n = 1'b1;
    edges(DT + 6);
  endtask

  task automatic t_reset_first_on();
    chk(hi_gate, 1'b0, "R9 hi low in reset");
    chk(lo_gate, 1'b0, "R9 lo low in reset");
    rst_ni = 1'b1;
    edges(1);
    hi_cmd = 1'b1;
    edges(DT + 1);
    chk(hi_gate, 1'b0, "R9 first on not early");
    edges(1);
    chk(hi_gate, 1'b1, "R9 R4 first on at DT+2");
  endtask

  task automatic t_hi_off();
    hi_cmd = 1'b0;
    edges(2);
    chk(hi_gate, 1'b1, "R1 hi still on at edge 2");
    edges(1);
    chk(hi_gate, 1'b0, "R1 hi off at edge 3");
  endtask

  task automatic t_lo_matched();
    idle();
    lo_cmd = 1'b1;
    edges(DT + 1);
    chk(lo_gate, 1'b0, "R10 lo on not early");
    edges(1);
    chk(lo_gate, 1'b1, "R10 R4 lo on at DT+2");
    lo_cmd = 1'b0;
    edges(2);
    chk(lo_gate, 1'b1, "R10 lo still on at edge 2");
    edges(1);
    chk(lo_gate, 1'b0, "R10 R1 lo off at edge 3");
  endtask

  task automatic t_swap();
    idle();
    lo_cmd = 1'b1;
    edges(DT + 4);
    lo_cmd = 1'b0; hi_cmd = 1'b1;
    edges(3);
    chk(lo_gate, 1'b0, "R5 lo off at edge 3");
    edges(DT - 1);
    chk(hi_gate, 1'b0, "R5 hi not before gap");
    edges(1);
    chk(hi_gate, 1'b1, "R5 hi on at DT+3");
    hi_cmd = 1'b0; lo_cmd = 1'b1;
    edges(DT + 2);
    chk(lo_gate, 1'b0, "R5 lo not before gap");
    edges(1);
    chk(lo_gate, 1'b1, "R5 lo on at DT+3");
  endtask

  task automatic t_overlap();
    idle();
    hi_cmd = 1'b1;
    edges(DT + 4);
    lo_cmd = 1'b1;
    edges(3);
    chk(hi_gate, 1'b0, "R3 hi off on overlap");
    edges(2 * DT);
    chk(hi_gate, 1'b0, "R3 hi held off");
    chk(lo_gate, 1'b0, "R3 lo held off");
    hi_cmd = 1'b0;
    edges(DT + 1);
    chk(lo_gate, 1'b0, "R3 lo not early after overlap");
    edges(1);
    chk(lo_gate, 1'b1, "R3 lo on after overlap ends");
  endtask

  task automatic t_retrigger();
    idle();
    lo_cmd = 1'b1;
    edges(DT + 4);
    lo_cmd = 1'b0;
    edges(1);
    lo_cmd = 1'b1;
    edges(2);
    chk(lo_gate, 1'b0, "R6 lo off after glitch");
    edges(DT - 1);
    chk(lo_gate, 1'b0, "R6 lo waits dead time");
    edges(1);
    chk(lo_gate, 1'b1, "R6 lo back on at DT+3");
  endtask

  task automatic t_abandon();
    idle();
    hi_cmd = 1'b1;
    edges(DT / 2);
    hi_cmd = 1'b0;
    edges(DT + 4);
    chk(hi_gate, 1'b0, "R7 abandoned stays low");
    hi_cmd = 1'b1;
    edges(DT + 1);
    chk(hi_gate, 1'b0, "R7 full wait restarted");
    edges(1);
    chk(hi_gate, 1'b1, "R7 on after full wait");
  endtask

  task automatic t_shutdown();
    idle();
    hi_cmd = 1'b1;
    edges(DT + 4);
    shdn_n = 1'b0;
    edges(2);
    chk(hi_gate, 1'b1, "R8 hi on at edge 2");
    edges(1);
    chk(hi_gate, 1'b0, "R8 hi off at edge 3");
    edges(2 * DT);
    chk(hi_gate, 1'b0, "R8 held off");
    shdn_n = 1'b1;
    edges(DT + 1);
    chk(hi_gate, 1'b0, "R8 not early after release");
    edges(1);
    chk(hi_gate, 1'b1, "R8 on at DT+2 after release");
  endtask

  initial begin
    edges(4);
    t_reset_first_on();
    t_hi_off();
    t_lo_matched();
    t_swap();
    t_overlap();
    t_retrigger();
    t_abandon();
    t_shutdown();
    idle();
    checks++;
    if (overlap_cnt != 0) begin
      failures++;
      $display("FAIL R2 both gates high: actual=%0d cycles expected=0", overlap_cnt);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule